// File: doc/BRIEF.md
# History-Confidence Last Value Predictor

This block guesses the result of a load before memory returns it. A direct-mapped array holds, for each line, the value most recently loaded by the loads that map there, together with a short shift register recording whether the recent guesses for that line were right. A lookup presents a load's program counter and receives the stored value plus a flag saying whether the pipeline should speculate with it. A resolve presents the same program counter with the value memory actually returned; the line's outcome history and its value are then updated.

The flag comes from a one-bit-per-pattern decision table, addressed by the line's outcome history and loaded through a small write port, so that an offline profile can choose exactly which histories are trusted. A strict mode input replaces the table with the rule "trust only a history of all ones", which suits machines where a wrong guess is very costly. After reset the block walks through every line and clears it, and signals readiness when the walk is over.

Top module: `lvp_hist_pred`

## Requirements
- R1: The line used by a lookup or resolve is selected by program counter bits [LINE_BITS+1:2]; bits [1:0] and all bits above LINE_BITS+1 are ignored, so program counters that differ only there share a line (no tag, no valid bit).
- R2: A lookup accepted in cycle t (lk_valid high while ready is high) produces rsp_valid high in cycle t+2, carrying the line's stored value on rsp_value and the decision on rsp_predict; in cycles with no such lookup two cycles before, rsp_valid is low.
- R3: A resolve shifts one outcome bit into the line's history at bit 0 and drops bit HIST_W-1; the bit is 1 when the resolved value equals the value stored in the line, otherwise 0.
- R4: Every resolve replaces the line's stored value with the resolved value, whether the outcome bit was 1 or 0.
- R5: With strict_mode low, rsp_predict equals the decision table entry whose address is the line's history (history bit i is address bit i).
- R6: With strict_mode high, rsp_predict is 1 exactly when every history bit is 1, whatever the decision table holds.
- R7: A cycle with tbl_we high stores tbl_bit at table address tbl_addr; reset sets every table entry to 0, so no prediction is made until the table is loaded.
- R8: After reset, ready stays low while all 2^LINE_BITS lines are cleared to value 0 and history 0, then rises and stays high; lookups and resolves presented while ready is low are ignored.
- R9: A lookup presented in the same cycle as a resolve to the same line returns the line's contents from before that resolve; a lookup presented two or more cycles after a resolve sees its update.
- R10: Resolves to the same line in consecutive cycles each compare against the value, and shift into the history, left by the one before.
- R11: rsp_predict is low whenever rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ready | output | 1 | High once the post-reset clear of all lines is complete |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | PC_W | Program counter of the load being looked up |
| rsp_valid | output | 1 | Lookup response valid, two cycles after the request |
| rsp_value | output | VAL_W | Stored value of the selected line |
| rsp_predict | output | 1 | 1 when the pipeline may speculate with rsp_value |
| rs_valid | input | 1 | Resolve request |
| rs_pc | input | PC_W | Program counter of the load being resolved |
| rs_value | input | VAL_W | Value actually loaded from memory |
| strict_mode | input | 1 | 1 selects the all-ones-only rule instead of the table |
| tbl_we | input | 1 | Decision table write enable |
| tbl_addr | input | HIST_W | Decision table entry to write |
| tbl_bit | input | 1 | Value written into that entry |

## Verification
The hardest situation to reach from the ports is a resolve whose read of the line races the write of the previous resolve to the same line, since only back-to-back resolves in adjacent cycles create it. The bench drives two resolves on consecutive cycles to a fresh line, the first changing the value and the second repeating it, and loads the table so that only the history that a correctly forwarded compare would produce allows a prediction. The history itself is never visible, so each shift order and outcome is checked by arranging the table or strict mode so that exactly one history pattern raises rsp_predict.

// File: rtl/lvp_pkg.sv
package lvp_pkg;

  // Default geometry of the predictor.
  localparam int LVP_PC_W      = 32;
  localparam int LVP_LINE_BITS = 11;
  localparam int LVP_HIST_W    = 8;
  localparam int LVP_VAL_W     = 64;

  // Which rule turns a history into a predict decision.
  typedef enum logic {
    RULE_TABLE    = 1'b0,
    RULE_ALL_ONES = 1'b1
  } rule_e;

endpackage

// File: rtl/lvp_line_store.sv
// One write port, two registered read ports, no reset: maps onto block RAM
// (replicated per read port when the device has only dual-port RAM).
module lvp_line_store #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [ADDR_W-1:0] rb_addr,
  output logic [DATA_W-1:0] rb_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Read-first: a read in the same cycle as a write returns the old word.
  always_ff @(posedge clk) begin
    ra_data <= mem[ra_addr];
  end

  always_ff @(posedge clk) begin
    rb_data <= mem[rb_addr];
  end
endmodule

// File: rtl/lvp_clear_seq.sv
// Walks every line once after reset so that the RAMs need no reset network.
module lvp_clear_seq #(
  parameter int LINE_BITS = 11
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic                 busy,
  output logic [LINE_BITS-1:0] clr_addr
);
  localparam logic [LINE_BITS-1:0] LAST = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b1;
      clr_addr <= '0;
    end else if (busy) begin
      clr_addr <= clr_addr + 1'b1;
      if (clr_addr == LAST) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/lvp_decide.sv
// Second lookup stage: turns the line history into a predict flag and
// registers the response.
module lvp_decide
  import lvp_pkg::*;
#(
  parameter int HIST_W = 8,
  parameter int VAL_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tbl_we,
  input  logic [HIST_W-1:0] tbl_addr,
  input  logic              tbl_bit,
  input  rule_e             rule,
  input  logic              en,
  input  logic [HIST_W-1:0] hist_in,
  input  logic [VAL_W-1:0]  value_in,
  output logic              rsp_valid,
  output logic [VAL_W-1:0]  rsp_value,
  output logic              rsp_predict
);
  localparam int TBL_N = 1 << HIST_W;

  logic [TBL_N-1:0] tbl;
  logic             allow;

  always_ff @(posedge clk) begin
    if (rst) tbl <= '0;
    else if (tbl_we) tbl[tbl_addr] <= tbl_bit;
  end

  always_comb begin
    unique case (rule)
      RULE_ALL_ONES: allow = &hist_in;
      default:       allow = tbl[hist_in];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_predict <= 1'b0;
      rsp_value   <= '0;
    end else begin
      rsp_valid   <= en;
      rsp_predict <= en & allow;
      if (en) rsp_value <= value_in;
    end
  end
endmodule

// File: rtl/lvp_hist_pred.sv
module lvp_hist_pred
  import lvp_pkg::*;
#(
  parameter int PC_W      = LVP_PC_W,
  parameter int LINE_BITS = LVP_LINE_BITS,
  parameter int HIST_W    = LVP_HIST_W,
  parameter int VAL_W     = LVP_VAL_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic              ready,
  input  logic              lk_valid,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              rsp_valid,
  output logic [VAL_W-1:0]  rsp_value,
  output logic              rsp_predict,
  input  logic              rs_valid,
  input  logic [PC_W-1:0]   rs_pc,
  input  logic [VAL_W-1:0]  rs_value,
  input  logic              strict_mode,
  input  logic              tbl_we,
  input  logic [HIST_W-1:0] tbl_addr,
  input  logic              tbl_bit
);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = LINE_BITS + IDX_LO - 1;

  logic                 busy;
  logic [LINE_BITS-1:0] clr_addr;

  logic [LINE_BITS-1:0] lk_idx, rs_idx;
  assign lk_idx = lk_pc[IDX_HI:IDX_LO];
  assign rs_idx = rs_pc[IDX_HI:IDX_LO];

  // Lookup stage 1 and resolve stage 1 registers.
  logic                 lk_v1;
  logic                 rs_v1;
  logic [LINE_BITS-1:0] rs_idx1;
  logic [VAL_W-1:0]     rs_true1;

  // Copy of the last write, for a resolve that read alongside it.
  logic                 w_v;
  logic [LINE_BITS-1:0] w_idx;
  logic [VAL_W-1:0]     w_val;
  logic [HIST_W-1:0]    w_hist;

  // RAM read data.
  logic [VAL_W-1:0]  lk_val_rd, rs_val_rd;
  logic [HIST_W-1:0] lk_hist_rd, rs_hist_rd;

  // Resolve update.
  logic              fwd;
  logic [VAL_W-1:0]  cur_val;
  logic [HIST_W-1:0] cur_hist;
  logic              hit;
  logic [HIST_W:0]   shifted;
  logic [HIST_W-1:0] new_hist;

  // Shared write port.
  logic                 wr_en;
  logic [LINE_BITS-1:0] wr_addr;
  logic [VAL_W-1:0]     wr_val;
  logic [HIST_W-1:0]    wr_hist;

  lvp_clear_seq #(.LINE_BITS(LINE_BITS)) u_clear (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .clr_addr (clr_addr)
  );

  assign ready = ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_v1    <= 1'b0;
      rs_v1    <= 1'b0;
      rs_idx1  <= '0;
      rs_true1 <= '0;
    end else begin
      lk_v1    <= lk_valid & ~busy;
      rs_v1    <= rs_valid & ~busy;
      rs_idx1  <= rs_idx;
      rs_true1 <= rs_value;
    end
  end

  lvp_line_store #(.ADDR_W(LINE_BITS), .DATA_W(VAL_W)) u_values (
    .clk     (clk),
    .we      (wr_en),
    .waddr   (wr_addr),
    .wdata   (wr_val),
    .ra_addr (lk_idx),
    .ra_data (lk_val_rd),
    .rb_addr (rs_idx),
    .rb_data (rs_val_rd)
  );

  lvp_line_store #(.ADDR_W(LINE_BITS), .DATA_W(HIST_W)) u_hists (
    .clk     (clk),
    .we      (wr_en),
    .waddr   (wr_addr),
    .wdata   (wr_hist),
    .ra_addr (lk_idx),
    .ra_data (lk_hist_rd),
    .rb_addr (rs_idx),
    .rb_data (rs_hist_rd)
  );

  // Outcome compare and history shift (new bit enters at bit 0).
  always_comb begin
    fwd      = w_v && (w_idx == rs_idx1);
    cur_val  = fwd ? w_val  : rs_val_rd;
    cur_hist = fwd ? w_hist : rs_hist_rd;
    hit      = (cur_val == rs_true1);
    shifted  = {cur_hist, hit};
    new_hist = shifted[HIST_W-1:0];
  end

  always_comb begin
    if (busy) begin
      wr_en   = 1'b1;
      wr_addr = clr_addr;
      wr_val  = '0;
      wr_hist = '0;
    end else begin
      wr_en   = rs_v1;
      wr_addr = rs_idx1;
      wr_val  = rs_true1;
      wr_hist = new_hist;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      w_v    <= 1'b0;
      w_idx  <= '0;
      w_val  <= '0;
      w_hist <= '0;
    end else begin
      w_v    <= rs_v1 & ~busy;
      w_idx  <= rs_idx1;
      w_val  <= rs_true1;
      w_hist <= new_hist;
    end
  end

  lvp_decide #(.HIST_W(HIST_W), .VAL_W(VAL_W)) u_decide (
    .clk         (clk),
    .rst         (rst),
    .tbl_we      (tbl_we),
    .tbl_addr    (tbl_addr),
    .tbl_bit     (tbl_bit),
    .rule        (strict_mode ? RULE_ALL_ONES : RULE_TABLE),
    .en          (lk_v1),
    .hist_in     (lk_hist_rd),
    .value_in    (lk_val_rd),
    .rsp_valid   (rsp_valid),
    .rsp_value   (rsp_value),
    .rsp_predict (rsp_predict)
  );
endmodule

// File: rtl/lvp_hist_pred_chk.sv
module lvp_hist_pred_chk (
  input logic clk,
  input logic rst,
  input logic ready,
  input logic lk_valid,
  input logic rsp_valid,
  input logic rsp_predict
);
  // R8: once the clear walk has ended, ready does not drop without reset.
  assert_ready_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

  // R8: no response can appear while lines are still being cleared.
  assert_quiet_while_clearing_R8: assert property (@(posedge clk) disable iff (rst)
    !ready |-> !rsp_valid);

  // R2: an accepted lookup answers exactly two cycles later.
  assert_rsp_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && ready) |=> ##1 rsp_valid);

  // R2: no response without a lookup two cycles before.
  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (rst)
    !(lk_valid && ready) |=> ##1 !rsp_valid);

  // R11: the predict flag never stands alone.
  assert_predict_gated_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_predict |-> rsp_valid);
endmodule

bind lvp_hist_pred lvp_hist_pred_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .ready       (ready),
  .lk_valid    (lk_valid),
  .rsp_valid   (rsp_valid),
  .rsp_predict (rsp_predict)
);

// File: tb/lvp_hist_pred_tb.sv
module lvp_hist_pred_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W      = 32;
  localparam int LINE_BITS = 11;
  localparam int HIST_W    = 8;
  localparam int VAL_W     = 64;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ready;
  logic              lk_valid = 1'b0;
  logic [PC_W-1:0]   lk_pc = '0;
  logic              rsp_valid;
  logic [VAL_W-1:0]  rsp_value;
  logic              rsp_predict;
  logic              rs_valid = 1'b0;
  logic [PC_W-1:0]   rs_pc = '0;
  logic [VAL_W-1:0]  rs_value = '0;
  logic              strict_mode = 1'b0;
  logic              tbl_we = 1'b0;
  logic [HIST_W-1:0] tbl_addr = '0;
  logic              tbl_bit = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit reported = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lvp_hist_pred #(.PC_W(PC_W), .LINE_BITS(LINE_BITS), .HIST_W(HIST_W), .VAL_W(VAL_W)) u_dut (
    .clk(clk), .rst(rst), .ready(ready),
    .lk_valid(lk_valid), .lk_pc(lk_pc),
    .rsp_valid(rsp_valid), .rsp_value(rsp_value), .rsp_predict(rsp_predict),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_value(rs_value),
    .strict_mode(strict_mode),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_bit(tbl_bit)
  );

  // Line addresses (index = pc[12:2]).
  localparam logic [PC_W-1:0] PC_A   = 32'h0000_1000;
  localparam logic [PC_W-1:0] PC_B   = 32'h0000_1004;
  localparam logic [PC_W-1:0] PC_C   = 32'h0000_1008;
  localparam logic [PC_W-1:0] PC_D   = 32'h0000_100C;
  localparam logic [PC_W-1:0] PC_E   = 32'h0000_1010;
  localparam logic [PC_W-1:0] PC_G   = 32'h0000_1018;
  localparam logic [PC_W-1:0] PC_F   = 32'h0000_0014;

  task automatic check(input bit ok, input string req, input logic [VAL_W-1:0] act,
                       input logic [VAL_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    end
  endtask

  task automatic lookup(input logic [PC_W-1:0] pc, output logic [VAL_W-1:0] v,
                        output logic p, output logic vld);
    @(negedge clk); lk_valid = 1'b1; lk_pc = pc;
    @(negedge clk); lk_valid = 1'b0;
    @(negedge clk); v = rsp_value; p = rsp_predict; vld = rsp_valid;
  endtask

  task automatic resolve(input logic [PC_W-1:0] pc, input logic [VAL_W-1:0] val);
    @(negedge clk); rs_valid = 1'b1; rs_pc = pc; rs_value = val;
    @(negedge clk); rs_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic tbl_write(input logic [HIST_W-1:0] a, input logic b);
    @(negedge clk); tbl_we = 1'b1; tbl_addr = a; tbl_bit = b;
    @(negedge clk); tbl_we = 1'b0;
  endtask

  task automatic wait_ready();
    while (ready !== 1'b1) @(negedge clk);
  endtask

  task automatic expect_lookup(input logic [PC_W-1:0] pc, input logic [VAL_W-1:0] ev,
                               input logic ep, input string req);
    logic [VAL_W-1:0] v; logic p; logic vld;
    lookup(pc, v, p, vld);
    check(vld === 1'b1, {req, " rsp_valid"}, VAL_W'(vld), 1);
    check(v === ev, {req, " rsp_value"}, v, ev);
    check(p === ep, {req, " rsp_predict"}, VAL_W'(p), VAL_W'(ep));
  endtask

  // R8: clear walk, readiness and inputs ignored while clearing.
  task automatic t_init();
    logic [VAL_W-1:0] v; logic p; logic vld;
    repeat (20) @(negedge clk);
    check(ready === 1'b0, "R8 ready low during clear", VAL_W'(ready), 0);
    resolve(PC_F, 64'hDEAD_BEEF);          // line 5 already cleared: must be ignored
    lookup(PC_F, v, p, vld);
    check(vld === 1'b0, "R8 lookup ignored while clearing", VAL_W'(vld), 0);
    repeat ((1 << LINE_BITS) + 10) @(negedge clk);
    check(ready === 1'b1, "R8 ready high after clear", VAL_W'(ready), 1);
    expect_lookup(PC_F, 64'h0, 1'b0, "R8 resolve during clear ignored");
    expect_lookup(PC_A, 64'h0, 1'b0, "R8 cleared line");
  endtask

  // R2/R11: response timing and quiet cycles.
  task automatic t_timing();
    @(negedge clk); lk_valid = 1'b1; lk_pc = PC_A;
    @(negedge clk); lk_valid = 1'b0;
    check(rsp_valid === 1'b0, "R2 no response after one cycle", VAL_W'(rsp_valid), 0);
    @(negedge clk);
    check(rsp_valid === 1'b1, "R2 response after two cycles", VAL_W'(rsp_valid), 1);
    @(negedge clk);
    check(rsp_valid === 1'b0, "R2 single response", VAL_W'(rsp_valid), 0);
    check(rsp_predict === 1'b0, "R11 predict low when idle", VAL_W'(rsp_predict), 0);
  endtask

  // R3/R4/R6: history fills with hits; strict rule needs all ones.
  task automatic t_strict();
    strict_mode = 1'b1;
    resolve(PC_A, 64'h1234_5678_9ABC_DEF0);          // miss: hist 00000000
    for (int i = 0; i < 7; i++) resolve(PC_A, 64'h1234_5678_9ABC_DEF0); // 01111111
    expect_lookup(PC_A, 64'h1234_5678_9ABC_DEF0, 1'b0, "R6 seven ones not enough");
    resolve(PC_A, 64'h1234_5678_9ABC_DEF0);          // 11111111
    expect_lookup(PC_A, 64'h1234_5678_9ABC_DEF0, 1'b1, "R3 R6 all ones predicts");
    strict_mode = 1'b0;
    expect_lookup(PC_A, 64'h1234_5678_9ABC_DEF0, 1'b0, "R7 empty table no predict");
    strict_mode = 1'b1;
    resolve(PC_A, 64'h42);                           // miss: 11111110
    expect_lookup(PC_A, 64'h42, 1'b0, "R4 value replaced on miss, R3 zero shifted");
    strict_mode = 1'b0;
  endtask

  // R5/R7/R3 shift order via a single trusted pattern 00000101.
  task automatic t_table();
    tbl_write(8'h05, 1'b1);
    resolve(PC_B, 64'h0);                            // hit: 00000001
    expect_lookup(PC_B, 64'h0, 1'b0, "R5 pattern 01 untrusted");
    resolve(PC_B, 64'h5);                            // miss: 00000010
    resolve(PC_B, 64'h5);                            // hit: 00000101
    expect_lookup(PC_B, 64'h5, 1'b1, "R3 R5 pattern 101 trusted");
    strict_mode = 1'b1;
    expect_lookup(PC_B, 64'h5, 1'b0, "R6 table bypassed in strict mode");
    strict_mode = 1'b0;
    tbl_write(8'h05, 1'b0);
    expect_lookup(PC_B, 64'h5, 1'b0, "R7 entry cleared by write");
  endtask

  // R1: aliasing through ignored program counter bits.
  task automatic t_alias();
    resolve(PC_D + 32'h0000_2000 + 32'h2, 64'd77);
    expect_lookup(PC_D, 64'd77, 1'b0, "R1 alias shares line");
    expect_lookup(PC_B, 64'h5, 1'b0, "R1 neighbour line untouched");
  endtask

  // R9: lookup in the same cycle as a resolve sees old contents.
  task automatic t_collision();
    resolve(PC_E, 64'h11);
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = PC_E;
    rs_valid = 1'b1; rs_pc = PC_E; rs_value = 64'h22;
    @(negedge clk); lk_valid = 1'b0; rs_valid = 1'b0;
    @(negedge clk);
    check(rsp_valid === 1'b1, "R9 collision response valid", VAL_W'(rsp_valid), 1);
    check(rsp_value === 64'h11, "R9 collision returns old value", rsp_value, 64'h11);
    expect_lookup(PC_E, 64'h22, 1'b0, "R9 later lookup sees update");
  endtask

  // R10: consecutive resolves to one line.
  task automatic t_back_to_back();
    tbl_write(8'h01, 1'b1);
    @(negedge clk); rs_valid = 1'b1; rs_pc = PC_C; rs_value = 64'hAB;  // miss
    @(negedge clk); rs_value = 64'hAB;                                   // hit -> 01
    @(negedge clk); rs_valid = 1'b0;
    @(negedge clk);
    expect_lookup(PC_C, 64'hAB, 1'b1, "R10 second resolve sees first");
    tbl_write(8'h03, 1'b1);
    @(negedge clk); rs_valid = 1'b1; rs_pc = PC_G; rs_value = 64'h7;   // miss
    @(negedge clk);                                                      // hit
    @(negedge clk);                                                      // hit -> 011
    @(negedge clk); rs_valid = 1'b0;
    @(negedge clk);
    expect_lookup(PC_G, 64'h7, 1'b1, "R10 three in a row");
  endtask

  // R8: a second reset clears written lines again.
  task automatic t_rereset();
    resolve(PC_A, 64'h99);
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(ready === 1'b0, "R8 ready low after second reset", VAL_W'(ready), 0);
    wait_ready();
    strict_mode = 1'b1;
    expect_lookup(PC_A, 64'h0, 1'b0, "R8 values and histories cleared");
    strict_mode = 1'b0;
    expect_lookup(PC_C, 64'h0, 1'b0, "R7 table reset to zero");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_init();
    t_timing();
    t_strict();
    t_table();
    t_alias();
    t_collision();
    t_back_to_back();
    t_rereset();
    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end
endmodule